// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns characters from a small transmit queue into asynchronous serial frames on one output line. Each frame has a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then one or two high stop bits. The line rests high between frames. Bit timing comes from outside: a one-cycle `baud_tick` pulse marks each bit boundary, so every bit lasts exactly one tick period.

A set of static line-control inputs picks the character length, the parity kind (even, odd or forced to a constant), the stop-bit count and a held break condition. A separate control switches the queue between an eight-deep FIFO and a single holding slot. Characters enter through a valid/ready write port. A frame begins only when both the block enable and the transmit enable are high. The frame settings are captured when each frame starts, so a settings change takes effect only at a character boundary.

The controller is a state machine with six states. `ST_IDLE` holds the line high. `ST_START` drives the start bit. `ST_DATA` shifts the data bits out. `ST_PARITY` sends the parity bit. `ST_STOP1` and `ST_STOP2` send the stop bits. All transitions happen on a tick. IDLE goes to START when a character can be sent. START goes to DATA. DATA goes to PARITY, or to STOP1 when parity is off, after the last data bit. PARITY goes to STOP1. STOP1 goes to STOP2 when two stop bits are selected. Otherwise STOP1 goes straight to START if another character can be sent, and to IDLE if not. STOP2 goes to START or IDLE on the same condition.

Top module: `uart_tx_framer`

## Requirements
- R1: The line idles high. A frame is one low start bit, then the data bits least significant bit first, then high stop bits, each bit lasting one tick period.
- R2: `lc_wlen` selects the data bit count: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8. Data bits above that count are not sent.
- R3: With `lc_par_en`=1 and `lc_stick`=0, one parity bit follows the data. It makes the count of ones even when `lc_even`=1 and odd when `lc_even`=0.
- R4: With `lc_par_en`=1 and `lc_stick`=1, the parity bit is 0 when `lc_even`=1 and 1 when `lc_even`=0.
- R5: `lc_two_stop`=1 sends two stop bits instead of one.
- R6: While `lc_break`=1, `txd` is held low and no new frame begins. Queued characters are sent after break is released.
- R7: With `lc_fifo_en`=1 the queue holds 8 characters in order. `fifo_full` is set and `wr_ready` is low at 8 entries. `fifo_empty` is set at 0 entries.
- R8: With `lc_fifo_en`=0 the queue holds a single character. `fifo_full` is set as soon as it holds one.
- R9: No frame begins unless both `uart_en` and `tx_en` are 1.
- R10: `busy` rises with the start bit and falls only after the last stop bit period has ended. For 8 data bits, no parity and one stop bit, it stays high for 10 tick periods.
- R11: Line-control settings are captured at the start of each frame. A change made during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uart_en | input | 1 | Block enable |
| tx_en | input | 1 | Transmit enable |
| baud_tick | input | 1 | One-cycle pulse at each bit boundary |
| wr_valid | input | 1 | Write request into the queue |
| wr_data | input | 8 | Character to queue |
| wr_ready | output | 1 | Queue can accept a character |
| lc_wlen | input | 2 | Data length code (5 + code bits) |
| lc_par_en | input | 1 | Parity bit enable |
| lc_even | input | 1 | Even parity select, or stick value select |
| lc_stick | input | 1 | Constant parity select |
| lc_two_stop | input | 1 | Two stop bits |
| lc_break | input | 1 | Hold line low |
| lc_fifo_en | input | 1 | Eight-deep queue when 1, single slot when 0 |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A frame is on the line |
| fifo_full | output | 1 | Queue at capacity |
| fifo_empty | output | 1 | Queue holds nothing |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse, and that `lc_fifo_en` changes only while the queue is empty. They also assume break is not raised in the middle of a frame, because the start-gating property ties the rise of `busy` to the break and enable levels of the cycle before. The stimulus follows these rules. It generates the tick from a free-running divide-by-8 counter, and it changes line-control settings and the queue mode only after the line has drained. The single exception is the capture test, which changes the frame-format fields during a frame on purpose. It never changes break or queue mode there.

// File: rtl/uart_txf_pkg.sv
package uart_txf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } tx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       even;
        logic       stick;
        logic       two_stop;
    } frame_cfg_t;

    localparam int MIN_DATA_BITS = 5;

endpackage

// File: rtl/txf_fifo.sv
module txf_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             deep_en,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    count;
    logic [CW-1:0]    capacity;

    assign capacity = deep_en ? CW'(DEPTH) : CW'(1);
    assign full     = (count >= capacity);
    assign empty    = (count == '0);
    assign head     = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/txf_parity.sv
module txf_parity
    import uart_txf_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data,
    input  logic [1:0]       wlen,
    input  logic             even,
    input  logic             stick,
    output logic             pbit
);
    logic [WIDTH-1:0] masked;
    logic             ones_odd;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            masked[i] = (i < MIN_DATA_BITS + int'(wlen)) ? data[i] : 1'b0;
        end
    end

    assign ones_odd = ^masked;

    always_comb begin
        if (stick) begin
            pbit = ~even;
        end else if (even) begin
            pbit = ones_odd;
        end else begin
            pbit = ~ones_odd;
        end
    end

endmodule

// File: rtl/txf_fsm.sv
module txf_fsm
    import uart_txf_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             can_start,
    input  frame_cfg_t       cfg_in,
    input  logic [WIDTH-1:0] data_in,
    input  logic             pbit_in,
    output logic             load,
    output logic             line_bit,
    output logic             busy
);
    localparam int BCW = $clog2(WIDTH);

    tx_state_e        state, state_nx;
    logic [WIDTH-1:0] shreg;
    logic [BCW-1:0]   bitcnt;
    logic [BCW-1:0]   last_bit;
    frame_cfg_t       cfg_q;
    logic             pbit_q;
    logic             at_frame_end;

    assign last_bit     = BCW'(MIN_DATA_BITS - 1) + BCW'(cfg_q.wlen);
    assign at_frame_end = (state == ST_STOP2) ||
                          (state == ST_STOP1 && !cfg_q.two_stop);
    assign load         = tick && can_start &&
                          (state == ST_IDLE || at_frame_end);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (tick && can_start) state_nx = ST_START;
            end
            ST_START: begin
                if (tick) state_nx = ST_DATA;
            end
            ST_DATA: begin
                if (tick && bitcnt == last_bit) begin
                    state_nx = cfg_q.par_en ? ST_PARITY : ST_STOP1;
                end
            end
            ST_PARITY: begin
                if (tick) state_nx = ST_STOP1;
            end
            ST_STOP1: begin
                if (tick) begin
                    if (cfg_q.two_stop) state_nx = ST_STOP2;
                    else                state_nx = can_start ? ST_START : ST_IDLE;
                end
            end
            ST_STOP2: begin
                if (tick) state_nx = can_start ? ST_START : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // frame datapath: capture on load, shift during data bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            cfg_q  <= '0;
            pbit_q <= 1'b0;
        end else if (load) begin
            shreg  <= data_in;
            bitcnt <= '0;
            cfg_q  <= cfg_in;
            pbit_q <= pbit_in;
        end else if (tick && state == ST_DATA) begin
            shreg  <= shreg >> 1;
            bitcnt <= bitcnt + BCW'(1);
        end
    end

    // outputs
    always_comb begin
        line_bit = 1'b1;
        unique case (state)
            ST_IDLE:   line_bit = 1'b1;
            ST_START:  line_bit = 1'b0;
            ST_DATA:   line_bit = shreg[0];
            ST_PARITY: line_bit = pbit_q;
            ST_STOP1:  line_bit = 1'b1;
            ST_STOP2:  line_bit = 1'b1;
            default:   line_bit = 1'b1;
        endcase
        busy = (state != ST_IDLE);
    end

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_txf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uart_en,
    input  logic              tx_en,
    input  logic              baud_tick,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic [1:0]        lc_wlen,
    input  logic              lc_par_en,
    input  logic              lc_even,
    input  logic              lc_stick,
    input  logic              lc_two_stop,
    input  logic              lc_break,
    input  logic              lc_fifo_en,
    output logic              txd,
    output logic              busy,
    output logic              fifo_full,
    output logic              fifo_empty
);
    logic [DATA_W-1:0] head;
    logic              push;
    logic              load;
    logic              can_start;
    logic              pbit;
    logic              line_bit;
    frame_cfg_t        cfg_now;

    assign cfg_now   = '{wlen: lc_wlen, par_en: lc_par_en, even: lc_even,
                         stick: lc_stick, two_stop: lc_two_stop};
    assign wr_ready  = !fifo_full;
    assign push      = wr_valid && wr_ready;
    assign can_start = uart_en && tx_en && !fifo_empty && !lc_break;
    assign txd       = lc_break ? 1'b0 : line_bit;

    txf_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .deep_en   (lc_fifo_en),
        .push      (push),
        .push_data (wr_data),
        .pop       (load),
        .head      (head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    txf_parity #(.WIDTH(DATA_W)) u_par (
        .data  (head),
        .wlen  (lc_wlen),
        .even  (lc_even),
        .stick (lc_stick),
        .pbit  (pbit)
    );

    txf_fsm #(.WIDTH(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .can_start (can_start),
        .cfg_in    (cfg_now),
        .data_in   (head),
        .pbit_in   (pbit),
        .load      (load),
        .line_bit  (line_bit),
        .busy      (busy)
    );

endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic uart_en,
    input logic tx_en,
    input logic baud_tick,
    input logic wr_ready,
    input logic lc_break,
    input logic lc_fifo_en,
    input logic txd,
    input logic busy,
    input logic fifo_full,
    input logic fifo_empty
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !lc_break) |-> txd);

    assert_break_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lc_break |-> !txd);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !wr_ready);

    assert_full_empty_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    assert_single_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lc_fifo_en && !fifo_empty) |-> fifo_full);

    assert_gated_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(uart_en && tx_en && !lc_break && !fifo_empty));

    assert_tick_paced_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy != $past(busy)) |-> $past(baud_tick));

endmodule

bind uart_tx_framer uart_tx_framer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .uart_en    (uart_en),
    .tx_en      (tx_en),
    .baud_tick  (baud_tick),
    .wr_ready   (wr_ready),
    .lc_break   (lc_break),
    .lc_fifo_en (lc_fifo_en),
    .txd        (txd),
    .busy       (busy),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty)
);

// File: tb/uart_tx_framer_test.sv
module uart_tx_framer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       uart_en = 1'b0, tx_en = 1'b0, baud_tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_ready;
    logic [1:0] lc_wlen = 2'd3;
    logic       lc_par_en = 0, lc_even = 0, lc_stick = 0, lc_two_stop = 0;
    logic       lc_break = 0, lc_fifo_en = 1;
    logic       txd, busy, fifo_full, fifo_empty;

    int total = 0;
    int bad   = 0;
    int tcnt  = 0;

    typedef struct {
        logic [7:0] d;
        int         nb;
        bit         hp;
        bit         pb;
        bit         stk;
        int         ns;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    uart_tx_framer uut (
        .clk(clk), .rst_n(rst_n), .uart_en(uart_en), .tx_en(tx_en),
        .baud_tick(baud_tick), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .lc_wlen(lc_wlen), .lc_par_en(lc_par_en),
        .lc_even(lc_even), .lc_stick(lc_stick), .lc_two_stop(lc_two_stop),
        .lc_break(lc_break), .lc_fifo_en(lc_fifo_en), .txd(txd), .busy(busy),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    // tick every 8 clocks
    always @(negedge clk) begin
        if (!rst_n) begin
            tcnt = 0;
            baud_tick = 1'b0;
        end else begin
            baud_tick = (tcnt == 7);
            tcnt = (tcnt == 7) ? 0 : tcnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // driver: compute expected frame, push to scoreboard, then write
    task automatic send(input logic [7:0] d);
        exp_t e;
        logic [7:0] m;
        e.d   = d;
        e.nb  = 5 + int'(lc_wlen);
        e.hp  = lc_par_en;
        e.stk = lc_stick;
        e.ns  = lc_two_stop ? 2 : 1;
        m = '0;
        for (int i = 0; i < e.nb; i++) m[i] = d[i];
        if (lc_stick) e.pb = !lc_even;
        else          e.pb = lc_even ? ^m : ~^m;
        sb.push_back(e);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (sb.size() != 0 || busy || !fifo_empty) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    // monitor: decode each frame at mid-bit and compare
    task automatic grab_frame();
        exp_t       e;
        logic [7:0] got;
        logic [7:0] want;
        repeat (4) @(negedge clk);
        chk(txd == 1'b0, "R1 start bit", txd, 0);
        if (sb.size() == 0) begin
            chk(1'b0, "R9 unexpected frame", 1, 0);
            return;
        end
        e = sb.pop_front();
        got = '0;
        want = '0;
        for (int i = 0; i < e.nb; i++) begin
            repeat (8) @(negedge clk);
            got[i]  = txd;
            want[i] = e.d[i];
        end
        chk(got == want, "R1 R2 data bits", got, want);
        if (e.hp) begin
            repeat (8) @(negedge clk);
            chk(txd == e.pb, e.stk ? "R4 stick parity" : "R3 parity", txd, e.pb);
        end
        for (int s = 0; s < e.ns; s++) begin
            repeat (8) @(negedge clk);
            chk(txd == 1'b1, (s == 1) ? "R5 second stop" : "R1 stop bit", txd, 1);
        end
    endtask

    initial begin
        logic prev;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && prev && !txd && !lc_break) grab_frame();
            prev = txd;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cnt;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R1 reset idle line", txd, 1);
        chk(busy == 1'b0, "R10 reset busy", busy, 0);
        chk(fifo_empty == 1'b1, "R7 reset empty", fifo_empty, 1);
        chk(fifo_full == 1'b0 && wr_ready == 1'b1, "R7 reset full", fifo_full, 0);

        // R1 R10: 8N1 and busy length
        uart_en = 1; tx_en = 1;
        send(8'hA5);
        send(8'h3C);
        drain();
        send(8'h5E);
        @(negedge clk);
        while (!busy) @(negedge clk);
        cnt = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == 80, "R10 busy length 8N1", cnt, 80);
        drain();

        // R2 R3: lengths with even/odd parity
        lc_wlen = 2'd0; lc_par_en = 1; lc_even = 1;
        send(8'hF3); send(8'h16);
        drain();
        lc_wlen = 2'd1; lc_even = 0;
        send(8'hC9); send(8'h2A);
        drain();
        lc_wlen = 2'd2; lc_even = 1;
        send(8'h7F); send(8'h81);
        drain();
        // R4 stick parity both values
        lc_wlen = 2'd3; lc_stick = 1; lc_even = 1;
        send(8'hFF); send(8'h01);
        drain();
        lc_even = 0;
        send(8'h00); send(8'h6D);
        drain();
        // R5 two stop bits, with and without parity
        lc_stick = 0; lc_two_stop = 1;
        send(8'h55); send(8'hAA);
        drain();
        lc_par_en = 0; lc_wlen = 2'd1;
        send(8'h3B);
        drain();
        lc_two_stop = 0; lc_wlen = 2'd3;

        // R7 R9: fill the deep queue while transmit is off
        tx_en = 0;
        for (int i = 0; i < 8; i++) send(8'(8'h10 + 8'(i * 7)));
        @(negedge clk);
        chk(fifo_full == 1'b1, "R7 full at 8", fifo_full, 1);
        chk(wr_ready == 1'b0, "R7 ready low at 8", wr_ready, 0);
        repeat (40) @(negedge clk);
        chk(busy == 1'b0 && txd == 1'b1, "R9 tx_en low blocks", busy, 0);
        tx_en = 1; uart_en = 0;
        repeat (40) @(negedge clk);
        chk(busy == 1'b0 && txd == 1'b1, "R9 uart_en low blocks", busy, 0);
        uart_en = 1;
        drain();
        chk(fifo_empty == 1'b1, "R7 empty after drain", fifo_empty, 1);

        // R8 single slot
        lc_fifo_en = 0; tx_en = 0;
        send(8'hE4);
        @(negedge clk);
        chk(fifo_full == 1'b1 && wr_ready == 1'b0, "R8 full at 1", fifo_full, 1);
        tx_en = 1;
        drain();
        send(8'h4E); send(8'h99); send(8'h12);
        drain();
        lc_fifo_en = 1;

        // R6 break
        lc_break = 1;
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (txd) cnt++;
        end
        chk(cnt == 0, "R6 break holds low", cnt, 0);
        send(8'hB7);
        repeat (40) @(negedge clk);
        chk(busy == 1'b0 && txd == 1'b0, "R6 no start in break", busy, 0);
        lc_break = 0;
        drain();

        // R11 settings captured per frame
        send(8'h96);
        @(negedge clk);
        while (!busy) @(negedge clk);
        lc_wlen = 2'd0; lc_par_en = 1; lc_even = 1;
        send(8'h1B);
        drain();
        chk(sb.size() == 0, "R11 all frames seen", sb.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule